// File: doc/BRIEF.md
# Four-Bit Multimode Test Register

This block is a four-bit register that can work as ordinary storage or as test hardware at the edge of a logic cone. Two mode inputs pick one of four behaviours on every clock. In load mode it captures a four-bit parallel word. In shift mode it acts as a serial scan chain, taking data in at the top bit and presenting the bottom bit on a scan output. In signature mode it acts as a linear feedback shift register that folds the parallel inputs into its state each cycle, which compresses a stream of responses into a short signature. In clear mode it zeroes its state synchronously.

With the parallel inputs held at zero, signature mode becomes a pseudorandom pattern generator. Seeded with any non-zero value, it steps through all fifteen non-zero states before it repeats. A seed is normally scanned in or loaded in parallel, a run is made in signature mode, and the result is read back through the parallel outputs or shifted out serially.

Top module: `obs_test_reg`

## Requirements
- R1: With mode code {modeHi,modeLo} = 2'b11, the register loads parIn, and parOut equals that word after the next rising clock edge.
- R2: With mode code 2'b00, the register shifts right by one bit. scanIn enters parOut[3], and each parOut[i] takes the old parOut[i+1].
- R3: With mode code 2'b10, the next state is: bit3 = old bit3 XOR old bit0 XOR parIn[3]; bit2 = old bit3 XOR parIn[2]; bit1 = old bit2 XOR parIn[1]; bit0 = old bit1 XOR parIn[0].
- R4: With mode code 2'b01, parOut is 4'b0000 after the next rising clock edge, whatever its previous value and whatever parIn and scanIn are.
- R5: scanOut always equals parOut[0].
- R6: In mode 2'b10 with parIn = 0, starting from 4'b1000, parOut steps through 1000, 1100, 1110, 1111, 0111, 1011, 0101, 1010, 1101, 0110, 0011, 1001, 0100, 0010, 0001 and then returns to 1000. The period is exactly 15.
- R7: In mode 2'b10 with parIn = 0, the state 4'b0000 stays at 4'b0000 (the lock-up state), and no non-zero state ever goes to 4'b0000.
- R8: While rstN is low, parOut is 4'b0000 and scanOut is 0.
- R9: A fixed stream of parIn words applied in mode 2'b10 from a zero state leaves the signature that the R3 recurrence predicts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeHi | input | 1 | Upper bit of the mode code |
| modeLo | input | 1 | Lower bit of the mode code |
| scanIn | input | 1 | Serial data into bit 3 in shift mode |
| parIn | input | 4 | Parallel data word or response word |
| parOut | output | 4 | Register state |
| scanOut | output | 1 | Serial output, equal to bit 0 |

## Verification
The hardest condition to reach is a given state at the moment signature mode starts, because the register normally arrives at that state only through a long chain of feedback steps. The stimulus uses load mode to place each of the sixteen states directly. It then applies one signature step with each of the sixteen parallel words, which covers every pair of state and input. The full-period walk and the zero lock-up state are both reached from seeds that are loaded the same way.

// File: rtl/obs_test_pkg.sv
package obs_test_pkg;

  // Register width; the feedback taps below assume four bits.
  localparam int REG_W = 4;
  localparam int TOP_BIT = REG_W - 1;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_LOAD  = 2'b11
  } obsMode_e;

  typedef struct packed {
    logic loadEn;
    logic shiftEn;
    logic compressEn;
    logic clearEn;
  } obsStrobe_t;

endpackage

// File: rtl/obs_test_ctrl.sv
module obs_test_ctrl
  import obs_test_pkg::*;
(
  input  logic       modeHi,
  input  logic       modeLo,
  output obsStrobe_t strobes
);

  obsMode_e modeSel;

  assign modeSel = obsMode_e'({modeHi, modeLo});

  always_comb begin
    strobes = '0;
    unique case (modeSel)
      MODE_LOAD:  strobes.loadEn     = 1'b1;
      MODE_SHIFT: strobes.shiftEn    = 1'b1;
      MODE_SIG:   strobes.compressEn = 1'b1;
      MODE_CLEAR: strobes.clearEn    = 1'b1;
      default:    strobes = '0;
    endcase
  end

endmodule

// File: rtl/obs_test_dp.sv
module obs_test_dp
  import obs_test_pkg::*;
#(
  parameter int W = REG_W
)(
  input  logic         clk,
  input  logic         rstN,
  input  obsStrobe_t   strobes,
  input  logic         scanIn,
  input  logic [W-1:0] parIn,
  output logic [W-1:0] stateQ
);

  localparam int MSB = W - 1;

  logic [W-1:0] shiftSrc;   // value each bit receives in a plain right shift
  logic [W-1:0] sigNext;    // next value in signature mode
  logic [W-1:0] scanNext;   // next value in scan mode
  logic         feedback;

  assign feedback = stateQ[MSB] ^ stateQ[0];

  // Bit MSB takes the feedback term; each lower bit takes its upper neighbour.
  genvar gi;
  generate
    for (gi = 0; gi < MSB; gi++) begin : g_shift
      assign shiftSrc[gi] = stateQ[gi+1];
      assign scanNext[gi] = stateQ[gi+1];
    end
  endgenerate

  assign shiftSrc[MSB] = feedback;
  assign scanNext[MSB] = scanIn;
  assign sigNext       = shiftSrc ^ parIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
    end else if (strobes.clearEn) begin
      stateQ <= '0;
    end else if (strobes.loadEn) begin
      stateQ <= parIn;
    end else if (strobes.shiftEn) begin
      stateQ <= scanNext;
    end else if (strobes.compressEn) begin
      stateQ <= sigNext;
    end
  end

endmodule

// File: rtl/obs_test_reg.sv
module obs_test_reg
  import obs_test_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeHi,
  input  logic             modeLo,
  input  logic             scanIn,
  input  logic [REG_W-1:0] parIn,
  output logic [REG_W-1:0] parOut,
  output logic             scanOut
);

  obsStrobe_t strobes;
  logic [REG_W-1:0] stateQ;

  obs_test_ctrl u_ctrl (
    .modeHi  (modeHi),
    .modeLo  (modeLo),
    .strobes (strobes)
  );

  obs_test_dp #(.W(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .scanIn  (scanIn),
    .parIn   (parIn),
    .stateQ  (stateQ)
  );

  assign parOut  = stateQ;
  assign scanOut = stateQ[0];

endmodule

// File: rtl/obs_test_chk.sv
module obs_test_chk
  import obs_test_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             modeHi,
  input logic             modeLo,
  input logic             scanIn,
  input logic [REG_W-1:0] parIn,
  input logic [REG_W-1:0] parOut,
  input logic             scanOut
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (modeHi && modeLo) |=> parOut == $past(parIn)); // R1

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (!modeHi && !modeLo) |=> parOut == {$past(scanIn), $past(parOut[3:1])}); // R2

  AST_SIG_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (modeHi && !modeLo) |=> parOut[3] == ($past(parOut[3]) ^ $past(parOut[0]) ^ $past(parIn[3]))); // R3

  AST_SIG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (modeHi && !modeLo) |=> parOut[2:0] == ($past(parOut[3:1]) ^ $past(parIn[2:0]))); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!modeHi && modeLo) |=> parOut == '0); // R4

  AST_SCAN_TAP: assert property (@(posedge clk) disable iff (!rstN)
    scanOut == parOut[0]); // R5

  AST_NO_LOCKUP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (modeHi && !modeLo && parIn == '0 && parOut != '0) |=> parOut != '0); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (parOut == '0 && !scanOut)); // R8

endmodule

bind obs_test_reg obs_test_chk u_chk (.*);

// File: tb/obs_test_reg_test.sv
module obs_test_reg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeHi = 1'b0;
  logic       modeLo = 1'b0;
  logic       scanIn = 1'b0;
  logic [3:0] parIn = 4'h0;
  logic [3:0] parOut;
  logic       scanOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  obs_test_reg uut (
    .clk(clk), .rstN(rstN), .modeHi(modeHi), .modeLo(modeLo),
    .scanIn(scanIn), .parIn(parIn), .parOut(parOut), .scanOut(scanOut)
  );

  // Signature recurrence from R3, written arithmetically.
  function automatic logic [3:0] sigStep(input logic [3:0] s, input logic [3:0] p);
    int top;
    int rest;
    top  = ((s >> 3) + (s & 1) + (p >> 3)) % 2;
    rest = ((s >> 1) ^ (p & 7)) & 7;
    return 4'(top * 8 + rest);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns after the next rising edge.
  task automatic step(input logic [1:0] m, input logic s, input logic [3:0] p);
    @(negedge clk);
    {modeHi, modeLo} = m;
    scanIn = s;
    parIn = p;
    @(posedge clk);
    #1;
  endtask

  logic [3:0] seqTab [15] = '{4'b1000, 4'b1100, 4'b1110, 4'b1111, 4'b0111,
                              4'b1011, 4'b0101, 4'b1010, 4'b1101, 4'b0110,
                              4'b0011, 4'b1001, 4'b0100, 4'b0010, 4'b0001};

  initial begin
    logic [3:0] model;
    // R8: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset parOut", parOut, 4'h0);
    check("R8 reset scanOut", {3'b0, scanOut}, 4'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: load every word
    for (int v = 0; v < 16; v++) begin
      step(2'b11, 1'b0, 4'(v));
      check("R1 load", parOut, 4'(v));
      check("R5 scanOut", {3'b0, scanOut}, 4'(v % 2));
    end

    // R2/R5: scan shift with varied serial data
    step(2'b11, 1'b0, 4'b1011);
    model = 4'b1011;
    for (int k = 0; k < 12; k++) begin
      logic sb;
      sb = logic'((k * 7 + 1) % 3 == 0);
      step(2'b00, sb, 4'hF);
      model = 4'((sb ? 8 : 0) + model / 2);
      check("R2 shift", parOut, model);
      check("R5 scanOut", {3'b0, scanOut}, 4'(model % 2));
    end

    // R3: every state with every input word, one signature step each
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        step(2'b11, 1'b0, 4'(s));
        step(2'b10, 1'b1, 4'(p));
        check("R3 signature step", parOut, sigStep(4'(s), 4'(p)));
      end
    end

    // R4: clear from several states, with inputs active
    for (int s = 1; s < 16; s += 3) begin
      step(2'b11, 1'b0, 4'(s));
      step(2'b01, 1'b1, 4'hF);
      check("R4 clear", parOut, 4'h0);
    end

    // R6: full period from 1000
    step(2'b11, 1'b0, 4'b1000);
    check("R6 seed", parOut, seqTab[0]);
    for (int i = 1; i <= 15; i++) begin
      step(2'b10, 1'b0, 4'h0);
      check("R6 sequence", parOut, seqTab[i % 15]);
      if (i < 15) check("R7 no zero", {3'b0, parOut == 4'h0}, 4'h0);
    end

    // R7: lock-up state holds
    step(2'b01, 1'b0, 4'h0);
    for (int i = 0; i < 5; i++) begin
      step(2'b10, 1'b0, 4'h0);
      check("R7 lockup", parOut, 4'h0);
    end

    // R9: signature of a fixed stream
    step(2'b01, 1'b0, 4'h0);
    model = 4'h0;
    for (int k = 0; k < 20; k++) begin
      step(2'b10, 1'b0, 4'((k * 5 + 3) % 16));
      model = sigStep(model, 4'((k * 5 + 3) % 16));
    end
    check("R9 signature", parOut, model);

    // R8: asynchronous reset mid-run
    step(2'b11, 1'b0, 4'hA);
    #1 rstN = 1'b0;
    #1;
    check("R8 async reset", parOut, 4'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule